// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block collects up to 32 level-sensitive interrupt lines and drives two request outputs toward a processor: a normal request and a fast request. Each output has its own enable mask. A line reaches an output only while it is high and its bit is set in that output's mask. Software reaches the block over a plain word-addressed register bus with a single write strobe and a combinational read port. A write of one bit sets a mask bit through one word, and a write of one bit clears it through another, so bits can be changed without a read-modify-write.

Software can also raise interrupt line 0 on its own through a latch, and drop it again. That lets firmware test the delivery path, or signal itself, without an external source. The latch is ORed with external line 0. Status words return the raw line levels and, for each output, the levels after masking. Both outputs are registered and follow the masked levels one clock later.

Top module: `dual_intc`

## Requirements
- R1: `irqOut` equals, one clock later, the OR of all bits of (raw level AND normal mask).
- R2: `fiqOut` equals, one clock later, the OR of all bits of (raw level AND fast mask).
- R3: A write to word 2 ORs the data into the normal mask. A write to word 3 clears every mask bit that is 1 in the data. Reading word 2 returns the normal mask.
- R4: A write to word 10 ORs the data into the fast mask. A write to word 11 clears every mask bit that is 1 in the data. Reading word 10 returns the fast mask.
- R5: Reading word 0 returns the raw level AND the normal mask. Reading word 8 returns the raw level AND the fast mask. Reading word 1 or word 9 returns the raw level.
- R6: Raw level bit 0 is external line 0 OR the software latch, and raw level bit n (n>0) is external line n. A write to word 4 with data bit 0 at 1 sets the latch. A write to word 5 with data bit 0 at 1 clears it. Data bits 31..1 of these writes have no effect. Reading word 4 returns raw level bit 0 in bit 0 and zeros above it.
- R7: Reading words 3, 5 and 11, or any word other than 0, 1, 2, 4, 8, 9 and 10, returns 0.
- R8: Writes to words 0, 1, 8 and 9, and to any word other than 2, 3, 4, 5, 10 and 11, change neither mask nor the latch.
- R9: During and right after reset, both masks, the latch and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLines | input | 32 | Level-sensitive interrupt lines |
| busAddr | input | 6 | Word address of the register access |
| busWr | input | 1 | Write strobe, one write per cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for `busAddr`, combinational |
| irqOut | output | 1 | Registered normal interrupt request |
| fiqOut | output | 1 | Registered fast interrupt request |

## Verification
A single high line is walked across all 32 positions under complementary mask patterns, and then again with the patterns swapped. This shows that each bit is gated by its own mask bit and reaches the correct output, not the other one. A sweep with no line high catches stuck requests. Mask writes with overlapping set and clear patterns tell an OR or AND-NOT update apart from a plain overwrite. Software-latch writes with only the upper data bits set confirm that only bit 0 acts. Writes to the status words and to unused words, made while lines and masks are active, show that nothing moves.

// File: rtl/dual_intc_pkg.sv
package dual_intc_pkg;

  // Word addresses the register bus decodes
  localparam int unsigned WORD_IRQ_STAT = 0;
  localparam int unsigned WORD_RAW_A    = 1;
  localparam int unsigned WORD_IRQ_SET  = 2;
  localparam int unsigned WORD_IRQ_CLR  = 3;
  localparam int unsigned WORD_SW_SET   = 4;
  localparam int unsigned WORD_SW_CLR   = 5;
  localparam int unsigned WORD_FIQ_STAT = 8;
  localparam int unsigned WORD_RAW_B    = 9;
  localparam int unsigned WORD_FIQ_SET  = 10;
  localparam int unsigned WORD_FIQ_CLR  = 11;

  typedef struct packed {
    logic irqEnSet;
    logic irqEnClr;
    logic fiqEnSet;
    logic fiqEnClr;
    logic swSet;
    logic swClr;
  } wrStrobes_t;

  typedef enum logic [2:0] {
    RD_ZERO,
    RD_IRQ_STAT,
    RD_RAW,
    RD_IRQ_EN,
    RD_SW,
    RD_FIQ_STAT,
    RD_FIQ_EN
  } rdSel_t;

endpackage

// File: rtl/dual_intc_ctrl.sv
module dual_intc_ctrl
  import dual_intc_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  output wrStrobes_t        strobes,
  output rdSel_t            rdSel
);

  // Write decode: only the six writable words raise a strobe
  always_comb begin
    strobes = '0;
    if (busWr) begin
      case (busAddr)
        ADDR_W'(WORD_IRQ_SET): strobes.irqEnSet = 1'b1;
        ADDR_W'(WORD_IRQ_CLR): strobes.irqEnClr = 1'b1;
        ADDR_W'(WORD_FIQ_SET): strobes.fiqEnSet = 1'b1;
        ADDR_W'(WORD_FIQ_CLR): strobes.fiqEnClr = 1'b1;
        ADDR_W'(WORD_SW_SET):  strobes.swSet    = 1'b1;
        ADDR_W'(WORD_SW_CLR):  strobes.swClr    = 1'b1;
        default:               strobes          = '0;
      endcase
    end
  end

  // Read decode: everything not listed reads as zero
  always_comb begin
    case (busAddr)
      ADDR_W'(WORD_IRQ_STAT): rdSel = RD_IRQ_STAT;
      ADDR_W'(WORD_RAW_A):    rdSel = RD_RAW;
      ADDR_W'(WORD_IRQ_SET):  rdSel = RD_IRQ_EN;
      ADDR_W'(WORD_SW_SET):   rdSel = RD_SW;
      ADDR_W'(WORD_FIQ_STAT): rdSel = RD_FIQ_STAT;
      ADDR_W'(WORD_RAW_B):    rdSel = RD_RAW;
      ADDR_W'(WORD_FIQ_SET):  rdSel = RD_FIQ_EN;
      default:                rdSel = RD_ZERO;
    endcase
  end

endmodule

// File: rtl/dual_intc_dp.sv
module dual_intc_dp
  import dual_intc_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  wrStrobes_t      strobes,
  input  rdSel_t          rdSel,
  input  logic [NSRC-1:0] wrData,
  input  logic [NSRC-1:0] srcLines,
  output logic [NSRC-1:0] rdData,
  output logic [NSRC-1:0] rawLevel,
  output logic [NSRC-1:0] irqMask,
  output logic [NSRC-1:0] fiqMask,
  output logic            swLatch,
  output logic            irqOut,
  output logic            fiqOut
);

  localparam int unsigned NOUT = 2;

  logic [NOUT-1:0][NSRC-1:0] maskQ;
  logic [NOUT-1:0]           setStb;
  logic [NOUT-1:0]           clrStb;
  logic [NOUT-1:0]           reqQ;

  assign setStb = {strobes.fiqEnSet, strobes.irqEnSet};
  assign clrStb = {strobes.fiqEnClr, strobes.irqEnClr};

  // Software latch only feeds line 0
  always_ff @(posedge clk) begin
    if (!rstN) begin
      swLatch <= 1'b0;
    end else if (strobes.swSet && wrData[0]) begin
      swLatch <= 1'b1;
    end else if (strobes.swClr && wrData[0]) begin
      swLatch <= 1'b0;
    end
  end

  assign rawLevel = srcLines | {{(NSRC-1){1'b0}}, swLatch};

  // One mask bank and registered request per output
  for (genvar g = 0; g < NOUT; g++) begin : g_out
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ[g] <= '0;
        reqQ[g]  <= 1'b0;
      end else begin
        if (setStb[g]) begin
          maskQ[g] <= maskQ[g] | wrData;
        end else if (clrStb[g]) begin
          maskQ[g] <= maskQ[g] & ~wrData;
        end
        reqQ[g] <= |(rawLevel & maskQ[g]);
      end
    end
  end

  assign irqMask = maskQ[0];
  assign fiqMask = maskQ[1];
  assign irqOut  = reqQ[0];
  assign fiqOut  = reqQ[1];

  always_comb begin
    case (rdSel)
      RD_IRQ_STAT: rdData = rawLevel & maskQ[0];
      RD_FIQ_STAT: rdData = rawLevel & maskQ[1];
      RD_RAW:      rdData = rawLevel;
      RD_IRQ_EN:   rdData = maskQ[0];
      RD_FIQ_EN:   rdData = maskQ[1];
      RD_SW:       rdData = {{(NSRC-1){1'b0}}, rawLevel[0]};
      default:     rdData = '0;
    endcase
  end

endmodule

// File: rtl/dual_intc.sv
module dual_intc
  import dual_intc_pkg::*;
#(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NSRC-1:0]   srcLines,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [NSRC-1:0]   busWrData,
  output logic [NSRC-1:0]   busRdData,
  output logic              irqOut,
  output logic              fiqOut
);

  wrStrobes_t      strobes;
  rdSel_t          rdSel;
  logic [NSRC-1:0] rawLevel;
  logic [NSRC-1:0] irqMask;
  logic [NSRC-1:0] fiqMask;
  logic            swLatch;

  dual_intc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  dual_intc_dp #(.NSRC(NSRC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .rdSel    (rdSel),
    .wrData   (busWrData),
    .srcLines (srcLines),
    .rdData   (busRdData),
    .rawLevel (rawLevel),
    .irqMask  (irqMask),
    .fiqMask  (fiqMask),
    .swLatch  (swLatch),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );

endmodule

// File: rtl/dual_intc_chk.sv
module dual_intc_chk #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [NSRC-1:0]   srcLines,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [NSRC-1:0]   busWrData,
  input logic [NSRC-1:0]   busRdData,
  input logic              irqOut,
  input logic              fiqOut,
  input logic [NSRC-1:0]   rawLevel,
  input logic [NSRC-1:0]   irqMask,
  input logic [NSRC-1:0]   fiqMask,
  input logic              swLatch
);

  // R1
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == $past(|(rawLevel & irqMask)));

  // R2
  fiq_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut == $past(|(rawLevel & fiqMask)));

  // R3
  irq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(2)) |=> ((irqMask & $past(busWrData)) == $past(busWrData)));

  // R3
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(3)) |=> ((irqMask & $past(busWrData)) == '0));

  // R4
  fiq_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(10)) |=> ((fiqMask & $past(busWrData)) == $past(busWrData)));

  // R4
  fiq_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(11)) |=> ((fiqMask & $past(busWrData)) == '0));

  // R6
  sw_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == ADDR_W'(4) && busWrData[0]) |=> rawLevel[0]);

  // R6
  upper_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    rawLevel[NSRC-1:1] == srcLines[NSRC-1:1]);

  // R7
  clr_word_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(3) || busAddr == ADDR_W'(5) || busAddr == ADDR_W'(11)) |-> (busRdData == '0));

  // R8
  status_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && (busAddr == ADDR_W'(0) || busAddr == ADDR_W'(1) || busAddr == ADDR_W'(8) ||
               busAddr == ADDR_W'(9) || busAddr > ADDR_W'(11)))
    |=> ($stable(irqMask) && $stable(fiqMask) && $stable(swLatch)));

endmodule

bind dual_intc dual_intc_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dual_intc_bench.sv
module dual_intc_bench;

  localparam int unsigned NSRC   = 32;
  localparam int unsigned ADDR_W = 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NSRC-1:0]   srcLines = '0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWr = 1'b0;
  logic [NSRC-1:0]   busWrData = '0;
  logic [NSRC-1:0]   busRdData;
  logic              irqOut;
  logic              fiqOut;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [NSRC-1:0] mIrq = '0;
  logic [NSRC-1:0] mFiq = '0;
  logic            mSw  = 1'b0;

  dual_intc #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_dual_intc (
    .clk       (clk),
    .rstN      (rstN),
    .srcLines  (srcLines),
    .busAddr   (busAddr),
    .busWr     (busWr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .irqOut    (irqOut),
    .fiqOut    (fiqOut)
  );

  always #5 clk = ~clk;

  function automatic logic [NSRC-1:0] rawModel();
    return srcLines | {{(NSRC-1){1'b0}}, mSw};
  endfunction

  task automatic chk(input string tag, input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input int unsigned a, input logic [NSRC-1:0] d);
    @(negedge clk);
    busAddr = ADDR_W'(a);
    busWrData = d;
    busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
    busWrData = '0;
  endtask

  task automatic rdChk(input string tag, input int unsigned a, input logic [NSRC-1:0] exp);
    @(negedge clk);
    busAddr = ADDR_W'(a);
    #1;
    chk(tag, busRdData, exp);
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic outChk(input string tag);
    settle();
    chk({tag, " R1 irqOut"}, NSRC'(irqOut), NSRC'(|(rawModel() & mIrq)));
    chk({tag, " R2 fiqOut"}, NSRC'(fiqOut), NSRC'(|(rawModel() & mFiq)));
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < NSRC; i++) begin
      srcLines = NSRC'(1) << i;
      outChk(tag);
      rdChk("R5 irq status", 0, rawModel() & mIrq);
      rdChk("R5 fiq status", 8, rawModel() & mFiq);
      rdChk("R5 raw word1", 1, rawModel());
      rdChk("R5 raw word9", 9, rawModel());
    end
    srcLines = '0;
    outChk({tag, " idle"});
  endtask

  initial begin
    // R9: reset state with lines active
    srcLines = '1;
    repeat (3) @(negedge clk);
    chk("R9 irqOut in reset", NSRC'(irqOut), '0);
    chk("R9 fiqOut in reset", NSRC'(fiqOut), '0);
    rstN = 1'b1;
    srcLines = '0;
    #1;
    chk("R9 irqOut after reset", NSRC'(irqOut), '0);
    chk("R9 fiqOut after reset", NSRC'(fiqOut), '0);
    rdChk("R9 irq mask", 2, '0);
    rdChk("R9 fiq mask", 10, '0);
    rdChk("R9 latch", 4, '0);

    // R3: set ORs, clear removes only given bits
    wrReg(2, 32'h0000_00F0); mIrq |= 32'h0000_00F0;
    wrReg(2, 32'h0F00_0000); mIrq |= 32'h0F00_0000;
    rdChk("R3 set OR", 2, mIrq);
    wrReg(3, 32'h0300_0030); mIrq &= ~32'h0300_0030;
    rdChk("R3 clear", 2, mIrq);
    chk("R3 model", mIrq, 32'h0C00_00C0);
    rdChk("R4 fiq untouched by irq writes", 10, '0);

    // R4
    wrReg(10, 32'hA000_0005); mFiq |= 32'hA000_0005;
    wrReg(10, 32'h0000_0300); mFiq |= 32'h0000_0300;
    rdChk("R4 set OR", 10, mFiq);
    wrReg(11, 32'h2000_0101); mFiq &= ~32'h2000_0101;
    rdChk("R4 clear", 10, mFiq);
    chk("R4 model", mFiq, 32'h8000_0204);
    rdChk("R3 irq untouched by fiq writes", 2, mIrq);

    // R1/R2 latency: output holds until the next edge
    wrReg(3, '1); mIrq = '0;
    wrReg(11, '1); mFiq = '0;
    wrReg(2, 32'h0000_0010); mIrq = 32'h0000_0010;
    settle();
    @(negedge clk);
    srcLines = 32'h0000_0010;
    #1;
    chk("R1 no change before edge", NSRC'(irqOut), '0);
    @(negedge clk); #1;
    chk("R1 one clock later", NSRC'(irqOut), NSRC'(1));
    chk("R2 fiq stays low", NSRC'(fiqOut), '0);
    srcLines = '0;

    // R1/R2/R5 sweeps with complementary masks, then swapped
    wrReg(3, '1); wrReg(11, '1);
    wrReg(2, 32'h5555_5555); mIrq = 32'h5555_5555;
    wrReg(10, 32'hAAAA_AAAA); mFiq = 32'hAAAA_AAAA;
    sweep("even irq");
    wrReg(3, 32'h5555_5555); wrReg(2, 32'hAAAA_AAAA); mIrq = 32'hAAAA_AAAA;
    wrReg(11, 32'hAAAA_AAAA); wrReg(10, 32'h5555_5555); mFiq = 32'h5555_5555;
    sweep("odd irq");

    // R6: software latch
    wrReg(2, '1); mIrq = '1;
    wrReg(11, '1); mFiq = '0;
    wrReg(4, 32'hFFFF_FFFE);
    rdChk("R6 upper bits do not set", 1, '0);
    outChk("R6 upper bits");
    wrReg(4, 32'h0000_0001); mSw = 1'b1;
    rdChk("R6 latch raw", 1, 32'h1);
    rdChk("R6 word4 readback", 4, 32'h1);
    outChk("R6 latch drives irq");
    srcLines = 32'hF000_0000;
    rdChk("R6 word4 bit0 only", 4, 32'h1);
    rdChk("R6 raw merge", 1, 32'hF000_0001);
    srcLines = '0;
    wrReg(5, 32'hFFFF_FFFE);
    rdChk("R6 upper bits do not clear", 1, 32'h1);
    wrReg(5, 32'h0000_0001); mSw = 1'b0;
    rdChk("R6 latch cleared", 1, '0);
    outChk("R6 cleared");
    srcLines = 32'h0000_0001;
    rdChk("R6 external line 0", 4, 32'h1);
    srcLines = '0;

    // R7: zero reads with live state
    wrReg(4, 32'h1); mSw = 1'b1;
    wrReg(10, 32'h0000_FFFF); mFiq = 32'h0000_FFFF;
    srcLines = 32'h1234_5678;
    for (int a = 0; a < 64; a++) begin
      if (!(a inside {0, 1, 2, 4, 8, 9, 10})) rdChk("R7 zero read", a, '0);
    end

    // R8: ignored writes
    for (int a = 0; a < 64; a++) begin
      if (!(a inside {2, 3, 4, 5, 10, 11})) begin
        wrReg(a, '1);
        wrReg(a, '0);
      end
    end
    rdChk("R8 irq mask kept", 2, mIrq);
    rdChk("R8 fiq mask kept", 10, mFiq);
    rdChk("R8 latch kept", 1, rawModel());
    outChk("R8 outputs kept");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule